// File: doc/BRIEF.md
# Shared Cell Buffer Queue Manager

This block manages one shared cell memory that holds several linked-list queues: one queue for each output port plus a pool of idle cells. Every slot always belongs to exactly one queue. Each slot stores a cell and a next-slot pointer. Each queue is described by a head register and a tail register, and the queue is empty when the two are equal. The slot at each tail is held in reserve and never carries a queued cell.

After reset the block passes through two named states. `S_INIT` walks every slot once. It fills the slot with an all-zero idle cell and links it to the following slot. The transition to `S_RUN` happens on the clock edge that finishes the last slot. After that the block stays in `S_RUN` until the next reset.

In `S_RUN`, every clock cycle does one read and then one write:
- **Read.** The port picked by a round-robin counter is served. If that port's queue is empty, an idle cell is taken from the idle pool in its place. The slot that was read becomes the free slot.
- **Write.** The incoming cell is stored at the tail of the queue that its destination names. An invalid input goes to the idle pool instead. The free slot is then linked in as that queue's new reserved tail.

If the served port is empty and the idle pool has no readable cell, no slot is freed. That cycle reports a cell loss, and the incoming cell is dropped.

All outputs are registered. They show the result of a cycle one clock edge after that cycle.

Top module: `sbq_queue_mgr`

## Requirements
- R1: After reset is released, `ready` stays low for exactly DEPTH clock cycles. During that time `out_valid`, `out_idle` and `cell_loss` stay low.
- R2: `out_port` is 0 for the first cycle after `ready` rises. It then advances by one every cycle and wraps from NUM_PORTS-1 to 0.
- R3: A cell given with `in_valid`=1 and destination d appears later with `out_port`=d, `out_valid`=1 and `out_idle`=0. Cells sent to the same port leave in the order they arrived.
- R4: When the served port's queue is empty and idle cells remain, the output shows `out_valid`=1, `out_idle`=1 and an all-zero `out_cell`.
- R5: An input with `in_valid`=0 is stored in the idle pool as an all-zero cell. Its payload and destination never appear on any output, and the storage it would have used stays available.
- R6: Within a cycle the read comes before the write. A cell that arrives for the port being served in that same cycle is not emitted in that cycle.
- R7: At most DEPTH-NUM_PORTS-1 cells can be queued. If the served port is empty and the idle pool is exhausted, the output shows `out_valid`=0, `out_idle`=0 and `cell_loss`=1, and that cycle's incoming cell is discarded.
- R8: Inputs presented while `ready` is low have no effect on the queues.
- R9: In any cycle, the slot that is read is never the slot that is written. As a result, queued cells are delivered uncorrupted under long mixed traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one controller cycle per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming cell carries data (0 = idle input) |
| in_dest | input | $clog2(NUM_PORTS) | Destination port of the incoming cell |
| in_cell | input | CELL_W | Incoming cell payload |
| ready | output | 1 | High in `S_RUN` |
| out_valid | output | 1 | A cell was read in the reported cycle |
| out_idle | output | 1 | The cell that was read is an idle cell |
| out_port | output | $clog2(NUM_PORTS) | Port served in the reported cycle |
| out_cell | output | CELL_W | Cell that was read (zero when none) |
| cell_loss | output | 1 | The served port was empty and no idle cell was left |

## Verification
The bench builds the block with eight ports, a 16-bit cell and only 16 slots. This leaves seven cells of usable storage, so the idle pool can be exhausted within a few cycles. With those values the bench can reach the cell-loss case, recover from it, and reuse storage across many passes over the slot list. The eight-port default still exercises the round-robin wrap and per-port ordering. Keeping DEPTH small also keeps the initialisation count short enough to check exactly.

// File: rtl/sbq_pkg.sv
package sbq_pkg;

    typedef enum logic {
        S_INIT = 1'b0,
        S_RUN  = 1'b1
    } sbq_state_e;

endpackage

// File: rtl/sbq_rr_sel.sv
module sbq_rr_sel #(
    parameter int NUM_PORTS = 8,
    localparam int PORT_W = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [PORT_W-1:0] cur
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (adv) begin
            cur <= (cur == PORT_W'(NUM_PORTS - 1)) ? '0 : cur + 1'b1;
        end
    end

endmodule

// File: rtl/sbq_cell_mem.sv
module sbq_cell_mem #(
    parameter int DEPTH  = 256,
    parameter int CELL_W = 424,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int ENT_W = CELL_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [CELL_W-1:0] wr_cell,
    input  logic [PTR_W-1:0]  wr_next,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [CELL_W-1:0] rd_cell,
    output logic [PTR_W-1:0]  rd_next
);

    logic [ENT_W-1:0] mem [DEPTH];

    // read sees the value before this cycle's write
    assign {rd_cell, rd_next} = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= {wr_cell, wr_next};
        end
    end

    // R9: a slot is never read and refilled in the same cycle
    assert_slot_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_addr != wr_addr));

endmodule

// File: rtl/sbq_queue_mgr.sv
module sbq_queue_mgr
    import sbq_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int DEPTH     = 256,
    parameter int CELL_W    = 424,
    localparam int PORT_W = $clog2(NUM_PORTS),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int NQ     = NUM_PORTS + 1,
    localparam int QW     = $clog2(NQ),
    localparam int IDLE_Q = NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_dest,
    input  logic [CELL_W-1:0] in_cell,
    output logic              ready,
    output logic              out_valid,
    output logic              out_idle,
    output logic [PORT_W-1:0] out_port,
    output logic [CELL_W-1:0] out_cell,
    output logic              cell_loss
);

    sbq_state_e state_q, state_d;
    logic [PTR_W-1:0]  init_cnt_q;
    logic [PTR_W-1:0]  head_q [NQ];
    logic [PTR_W-1:0]  tail_q [NQ];
    logic [PORT_W-1:0] cur;
    logic              run, port_empty, idle_empty, starved, rd_en, wr_en;
    logic [QW-1:0]     rd_q, wr_q;
    logic [PTR_W-1:0]  rd_addr, rd_next, wr_addr, wr_next;
    logic [CELL_W-1:0] rd_cell, wr_cell;

    assign run   = (state_q == S_RUN);
    assign ready = run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_INIT;
            init_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_INIT) begin
                init_cnt_q <= init_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INIT:  if (init_cnt_q == PTR_W'(DEPTH - 1)) state_d = S_RUN;
            S_RUN:   state_d = S_RUN;
            default: state_d = S_INIT;
        endcase
    end

    sbq_rr_sel #(.NUM_PORTS(NUM_PORTS)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .cur   (cur)
    );

    // read selection: served port, or the idle pool when it is empty
    assign port_empty = (head_q[QW'(cur)] == tail_q[QW'(cur)]);
    assign idle_empty = (head_q[IDLE_Q] == tail_q[IDLE_Q]);
    assign starved    = run && port_empty && idle_empty;
    assign rd_en      = run && !starved;
    assign rd_q       = port_empty ? QW'(IDLE_Q) : QW'(cur);
    assign rd_addr    = head_q[rd_q];

    // write selection: init walk, or append to the target queue tail
    assign wr_q    = in_valid ? QW'(in_dest) : QW'(IDLE_Q);
    assign wr_en   = !run || rd_en;
    assign wr_addr = run ? tail_q[wr_q] : init_cnt_q;
    assign wr_next = run ? rd_addr : init_cnt_q + 1'b1;
    assign wr_cell = (run && in_valid) ? in_cell : '0;

    sbq_cell_mem #(.DEPTH(DEPTH), .CELL_W(CELL_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_cell (wr_cell),
        .wr_next (wr_next),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_cell (rd_cell),
        .rd_next (rd_next)
    );

    // head/tail pointers: port q reserves slot q, idle pool spans the rest
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                head_q[q] <= (q == IDLE_Q) ? PTR_W'(NUM_PORTS) : PTR_W'(q);
                tail_q[q] <= (q == IDLE_Q) ? PTR_W'(DEPTH - 1) : PTR_W'(q);
            end
        end else if (rd_en) begin
            head_q[rd_q] <= rd_next;
            tail_q[wr_q] <= rd_addr;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idle  <= 1'b0;
            out_port  <= '0;
            out_cell  <= '0;
            cell_loss <= 1'b0;
        end else begin
            out_valid <= rd_en;
            out_idle  <= rd_en && port_empty;
            out_cell  <= rd_en ? rd_cell : '0;
            cell_loss <= starved;
            if (run) begin
                out_port <= cur;
            end
        end
    end

    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (!out_valid && !cell_loss && !out_idle));

    assert_rr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid || cell_loss) && $past(out_valid || cell_loss)) |->
        (out_port == (($past(out_port) == PORT_W'(NUM_PORTS - 1)) ? '0 : $past(out_port) + 1'b1)));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_idle |-> (out_valid && out_cell == '0));

    assert_loss_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_loss |-> (!out_valid && !out_idle && out_cell == '0));

endmodule

// File: tb/tb_sbq_queue_mgr.sv
`timescale 1ns/1ps
module tb_sbq_queue_mgr;

    localparam int NP   = 8;
    localparam int DP   = 16;
    localparam int CW   = 16;
    localparam int CAP  = DP - NP - 1;
    localparam int NSTIM = 24;

    // stimulus vectors {valid, dest, cell}; expected results come from the queue model
    localparam logic [19:0] STIM [NSTIM] = '{
        {1'b1, 3'd0, 16'hA000}, {1'b1, 3'd2, 16'hA001}, {1'b0, 3'd5, 16'hDEAD},
        {1'b1, 3'd2, 16'hA002}, {1'b1, 3'd7, 16'hA003}, {1'b1, 3'd1, 16'hA004},
        {1'b0, 3'd3, 16'hBEEF}, {1'b1, 3'd2, 16'hA005}, {1'b1, 3'd0, 16'hA006},
        {1'b0, 3'd0, 16'hFACE}, {1'b1, 3'd4, 16'hA007}, {1'b1, 3'd4, 16'hA008},
        {1'b0, 3'd1, 16'hC0DE}, {1'b1, 3'd6, 16'hA009}, {1'b0, 3'd2, 16'h1234},
        {1'b1, 3'd3, 16'hA00A}, {1'b0, 3'd4, 16'h5678}, {1'b1, 3'd5, 16'hA00B},
        {1'b0, 3'd6, 16'h9ABC}, {1'b1, 3'd2, 16'hA00C}, {1'b0, 3'd7, 16'hDEF0},
        {1'b0, 3'd0, 16'h1111}, {1'b1, 3'd7, 16'hA00D}, {1'b0, 3'd1, 16'h2222}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_dest = '0;
    logic [CW-1:0] in_cell = '0;
    logic          ready, out_valid, out_idle, cell_loss;
    logic [2:0]    out_port;
    logic [CW-1:0] out_cell;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference queue model
    logic [CW-1:0] mq [NP][DP];
    int mrd [NP];
    int mwr [NP];
    int mcnt [NP];
    int stored;
    int rr;
    int loss_seen;

    always #2 clk = ~clk;

    sbq_queue_mgr #(.NUM_PORTS(NP), .DEPTH(DP), .CELL_W(CW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dest   (in_dest),
        .in_cell   (in_cell),
        .ready     (ready),
        .out_valid (out_valid),
        .out_idle  (out_idle),
        .out_port  (out_port),
        .out_cell  (out_cell),
        .cell_loss (cell_loss)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NP; p++) begin
            mrd[p] = 0;
            mwr[p] = 0;
            mcnt[p] = 0;
        end
        stored = 0;
        rr = 0;
    endtask

    // one controller cycle; called at a falling edge, returns at the next one
    task automatic step(input bit v, input logic [2:0] d, input logic [CW-1:0] c, input string tag);
        bit e_valid, e_idle, e_loss;
        logic [CW-1:0] e_cell;
        int e_port;
        in_valid = v;
        in_dest  = d;
        in_cell  = c;
        e_port = rr;
        e_loss = 1'b0;
        e_idle = 1'b0;
        e_cell = '0;
        e_valid = 1'b1;
        if (mcnt[rr] > 0) begin
            e_cell = mq[rr][mrd[rr]];
            mrd[rr] = (mrd[rr] + 1) % DP;
            mcnt[rr]--;
            stored--;
        end else if (stored < CAP) begin
            e_idle = 1'b1;
        end else begin
            e_valid = 1'b0;
            e_loss = 1'b1;
        end
        if (!e_loss && v) begin
            mq[d][mwr[d]] = c;
            mwr[d] = (mwr[d] + 1) % DP;
            mcnt[d]++;
            stored++;
        end
        rr = (rr + 1) % NP;
        @(posedge clk);
        @(negedge clk);
        if (e_loss) loss_seen++;
        chk(out_port == 3'(e_port), {tag, " R2 port"}, out_port, e_port);
        chk(out_valid == e_valid, {tag, " valid"}, out_valid, e_valid);
        chk(out_idle == e_idle, {tag, " R4 idle"}, out_idle, e_idle);
        chk(cell_loss == e_loss, {tag, " R7 loss"}, cell_loss, e_loss);
        chk(out_cell == e_cell, {tag, " R3 cell"}, out_cell, e_cell);
    endtask

    task automatic do_reset_and_init(input bit poke);
        int n;
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        @(negedge clk);
        chk(!ready && !out_valid && !cell_loss && !out_idle, "R1 reset state", ready, 0);
        rst_n = 1'b1;
        n = 0;
        // R8: stimulus during initialisation must leave the queues untouched
        in_valid = poke;
        in_dest  = 3'd0;
        in_cell  = 16'h7777;
        while (!ready && n < 4 * DP) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (!ready) begin
                chk(!out_valid && !cell_loss && !out_idle, "R1 quiet during init", out_valid, 0);
            end
        end
        chk(n == DP, "R1 init length", n, DP);
        in_valid = 1'b0;
    endtask

    initial begin
        loss_seen = 0;
        model_clear();
        do_reset_and_init(1'b1);

        // R8: first pass over all ports must show only idle cells
        for (int i = 0; i < NP; i++) begin
            step(1'b0, 3'd0, '0, "R8 after init");
        end

        // table walk: R3, R5 mixed traffic
        for (int i = 0; i < NSTIM; i++) begin
            step(STIM[i][19], STIM[i][18:16], STIM[i][15:0], "R3/R5 table");
        end
        for (int i = 0; i < 2 * NP; i++) begin
            step(1'b0, 3'd6, 16'hEEEE, "R5 drain");
        end
        chk(stored == 0, "R5 model drained", stored, 0);

        // R6: cell for the port being served this cycle
        begin
            int p;
            p = rr;
            step(1'b1, 3'(p), 16'hB6B6, "R6 same cycle");
            chk(out_idle == 1'b1, "R6 arrival not emitted early", out_idle, 1);
            for (int i = 0; i < NP; i++) begin
                step(1'b0, 3'd0, '0, "R6 follow");
            end
        end

        // R7: flood one port until storage runs out
        for (int i = 0; i < 3 * NP; i++) begin
            step(1'b1, 3'd7, 16'hC000 + 16'(i), "R7 flood");
        end
        chk(loss_seen > 0, "R7 loss reached", loss_seen, 1);
        for (int i = 0; i < 8 * NP; i++) begin
            step(1'b0, 3'd1, 16'hFFFF, "R7 recover");
        end
        chk(stored == 0, "R7 storage recovered", stored, 0);

        // R9: long mixed traffic reusing all slots many times
        for (int i = 0; i < 400; i++) begin
            step(((i % 3) != 0), 3'((i * 5) % NP), 16'h9000 + 16'(i), "R9 soak");
        end

        // R1: reset in the middle of traffic
        do_reset_and_init(1'b0);
        for (int i = 0; i < 2 * NP; i++) begin
            step(1'b1, 3'(i % NP), 16'h4000 + 16'(i), "R1 after re-reset");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule